// File: doc/BRIEF.md
# Byte SEC-DED Memory Codec

This block guards bytes kept in a memory array. On the write side, the encoder turns one data byte into a 13-bit stored word. Twelve of those bits form a Hamming code: its check bits sit at the power-of-two positions. The thirteenth bit is an overall parity bit. On the read side, the decoder takes a 13-bit word as it comes back from the array. It works out a 4-bit syndrome and the overall parity, and repairs any single flipped bit. A double error it reports as uncorrectable. It returns the byte together with the syndrome and a two-bit status code.

The two paths are independent. Each is qualified by a valid strobe and each has one register stage. A word presented with its valid high gives a result, with valid raised, on the next clock. While valid is low, the outputs keep their last values. The memory array itself lies outside the block.

Top module: `hsd_codec`

## Requirements
- R1: The stored word has bit i-1 holding code position i, for positions 1..12, and bit 12 holding the overall parity. Data bits 7 down to 0 occupy positions 3, 5, 6, 7, 9, 10, 11, 12 in that order. Check bits 1, 2, 4 and 8 give even parity over the positions whose index has that bit set. Bit 12 is the XOR of bits 11..0. For example, byte 0xC4 encodes to 13'h129C.
- R2: The encoder output and its valid appear one clock after `enc_valid_i` is sampled high, and `enc_valid_o` is low in a cycle that follows a low `enc_valid_i`.
- R3: Decoder outputs and `dec_valid_o` appear one clock after `dec_valid_i` is sampled high, and `dec_valid_o` is low otherwise.
- R4: `dec_syndrome_o` (bit 3 down to 0 = C8 C4 C2 C1) is the XOR of the check groups over positions 1..12. It equals the position of a single flipped bit among positions 1..12, and is 0 for an undamaged word.
- R5: An undamaged word yields status 0 (clean), with `dec_uncorr_o` low and the original byte.
- R6: A single flip at any of positions 1..12 yields status 1 (corrected) and the original byte.
- R7: A flip of bit 12 alone (the overall parity) yields syndrome 0, status 3 (parity bit only) and the original byte.
- R8: A nonzero syndrome with correct overall parity (any two flips) yields status 2, with `dec_uncorr_o` high. The byte output is then taken from the word without any correction.
- R9: A syndrome of 13 to 15 with wrong overall parity yields status 2 with `dec_uncorr_o` high. No bit is altered in that case.
- R10: While `dec_valid_i` is low, decoder data, syndrome and status outputs hold their values.
- R11: After synchronous reset, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_data_i | input | DATA_W | Byte to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_word_o | output | CODE_W+1 | Stored word: parity bit on top, code positions below |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_word_i | input | CODE_W+1 | Word read back from memory |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | DATA_W | Corrected or extracted byte |
| dec_syndrome_o | output | CHK_W | Syndrome, C8 in the top bit |
| dec_status_o | output | 2 | 0 clean, 1 corrected, 2 uncorrectable, 3 parity bit only |
| dec_uncorr_o | output | 1 | Uncorrectable error flag |

## Verification
The bench builds the codec with its default DATA_W of 8. That gives 4 check bits, a 12-position code and a 13-bit stored word. The size keeps all 256 bytes in reach, each under zero, all 13 single and all 78 double flips. A hand-computed vector table pins the exact worked layout, including the corrupted-byte output of a double error. The table also reaches the out-of-range syndrome 13 through a triple flip of check bits, a case no single or double flip can produce.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_DOUBLE = 2'd2,
    ST_PARBIT = 2'd3
  } dec_status_e;

  // Smallest k with 2^k >= data + k + 1
  function automatic int chk_bits(input int dw);
    int k;
    k = 1;
    while ((1 << k) < dw + k + 1) k++;
    return k;
  endfunction

endpackage

// File: rtl/hsd_encoder.sv
module hsd_encoder #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W:0]   word
);

  logic [CODE_W-1:0] code;
  logic              par;
  int                k;

  always_comb begin
    code = '0;
    k    = DATA_W - 1;
    // data MSB first into the non power-of-two positions
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        code[p-1] = data[k];
        k = k - 1;
      end
    end
    // even check bits; their own slots are still zero here
    for (int j = 0; j < CHK_W; j++) begin
      par = 1'b0;
      for (int p = 1; p <= CODE_W; p++) begin
        if (((p >> j) & 1) == 1) par = par ^ code[p-1];
      end
      code[(1 << j) - 1] = par;
    end
    word = {^code, code};
  end

endmodule

// File: rtl/hsd_syndrome.sv
module hsd_syndrome #(
  parameter int CHK_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic [CODE_W:0]  word,
  output logic [CHK_W-1:0] syn,
  output logic             par_err
);

  always_comb begin
    syn = '0;
    for (int j = 0; j < CHK_W; j++) begin
      for (int p = 1; p <= CODE_W; p++) begin
        if (((p >> j) & 1) == 1) syn[j] = syn[j] ^ word[p-1];
      end
    end
    par_err = ^word;
  end

endmodule

// File: rtl/hsd_correct.sv
module hsd_correct
  import hsd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic [CODE_W:0]   word,
  input  logic [CHK_W-1:0]  syn,
  input  logic              par_err,
  output logic [DATA_W-1:0] data,
  output dec_status_e       status
);

  logic [CODE_W-1:0] fixed;
  int                k;

  always_comb begin
    fixed = word[CODE_W-1:0];
    if (syn == '0) begin
      status = par_err ? ST_PARBIT : ST_CLEAN;
    end else if (!par_err) begin
      status = ST_DOUBLE;
    end else if (int'(syn) > CODE_W) begin
      status = ST_DOUBLE;
    end else begin
      status = ST_FIXED;
      fixed[int'(syn)-1] = ~fixed[int'(syn)-1];
    end

    data = '0;
    k    = DATA_W - 1;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        data[k] = fixed[p-1];
        k = k - 1;
      end
    end
  end

endmodule

// File: rtl/hsd_codec.sv
module hsd_codec
  import hsd_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W:0]   enc_word_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W:0]   dec_word_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [CHK_W-1:0]  dec_syndrome_o,
  output logic [1:0]        dec_status_o,
  output logic              dec_uncorr_o
);

  logic [CODE_W:0]   enc_word_c;
  logic [CHK_W-1:0]  syn_c;
  logic              par_err_c;
  logic [DATA_W-1:0] dec_data_c;
  dec_status_e       status_c;

  hsd_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_enc (
    .data (enc_data_i),
    .word (enc_word_c)
  );

  hsd_syndrome #(.CHK_W(CHK_W), .CODE_W(CODE_W)) u_syn (
    .word    (dec_word_i),
    .syn     (syn_c),
    .par_err (par_err_c)
  );

  hsd_correct #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_fix (
    .word    (dec_word_i),
    .syn     (syn_c),
    .par_err (par_err_c),
    .data    (dec_data_c),
    .status  (status_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid_o <= 1'b0;
      enc_word_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_word_o <= enc_word_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o    <= 1'b0;
      dec_data_o     <= '0;
      dec_syndrome_o <= '0;
      dec_status_o   <= ST_CLEAN;
      dec_uncorr_o   <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o     <= dec_data_c;
        dec_syndrome_o <= syn_c;
        dec_status_o   <= status_c;
        dec_uncorr_o   <= (status_c == ST_DOUBLE);
      end
    end
  end

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    enc_valid_i |=> enc_valid_o); // R2
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o); // R3
  AST_CLEAN_ZERO_SYN: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_o && dec_status_o == ST_CLEAN) |-> (dec_syndrome_o == '0)); // R5
  AST_FIX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_o && dec_status_o == ST_FIXED) |->
      (dec_syndrome_o != '0 && int'(dec_syndrome_o) <= CODE_W)); // R6
  AST_UNCORR_FLAG: assert property (@(posedge clk) disable iff (rst)
    dec_valid_o |-> (dec_uncorr_o == (dec_status_o == ST_DOUBLE))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_status_o) &&
                      $stable(dec_syndrome_o))); // R10

endmodule

// File: tb/hsd_codec_tb.sv
`timescale 1ns/1ps
module hsd_codec_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        enc_valid_i;
  logic [7:0]  enc_data_i;
  logic        enc_valid_o;
  logic [12:0] enc_word_o;
  logic        dec_valid_i;
  logic [12:0] dec_word_i;
  logic        dec_valid_o;
  logic [7:0]  dec_data_o;
  logic [3:0]  dec_syndrome_o;
  logic [1:0]  dec_status_o;
  logic        dec_uncorr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  hsd_codec #(.DATA_W(8)) u_dut (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_word_o(enc_word_o),
    .dec_valid_i(dec_valid_i), .dec_word_i(dec_word_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_syndrome_o(dec_syndrome_o), .dec_status_o(dec_status_o),
    .dec_uncorr_o(dec_uncorr_o)
  );

  // {word(16), data(8), syndrome(4), status(4)}
  localparam logic [31:0] TBL [8] = '{
    32'h129C_C4_0_0,   // R1 worked example, clean (R5)
    32'h129D_C4_1_1,   // R6 flip position 1
    32'h128C_C4_5_1,   // R6 flip position 5
    32'h128D_84_4_2,   // R8 flips 1 and 5, raw byte
    32'h0F77_FF_0_0,   // R5 all ones
    32'h0000_00_0_0,   // R5 all zeros
    32'h029C_C4_0_3,   // R7 parity bit alone
    32'h1215_C4_D_2    // R9 flips 1,4,8 -> syndrome 13
  };

  function automatic int dpos(input int i); // data bit 7-i position
    case (i)
      0: return 3;  1: return 5;  2: return 6;  3: return 7;
      4: return 9;  5: return 10; 6: return 11; default: return 12;
    endcase
  endfunction

  function automatic logic [12:0] m_encode(input logic [7:0] d);
    logic [12:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) w[dpos(i)-1] = d[7-i];
    w[0] = w[2] ^ w[4] ^ w[6] ^ w[8] ^ w[10];
    w[1] = w[2] ^ w[5] ^ w[6] ^ w[9] ^ w[10];
    w[3] = w[4] ^ w[5] ^ w[6] ^ w[11];
    w[7] = w[8] ^ w[9] ^ w[10] ^ w[11];
    w[12] = ^w[11:0];
    return w;
  endfunction

  function automatic logic [7:0] m_extract(input logic [12:0] w);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) d[7-i] = w[dpos(i)-1];
    return d;
  endfunction

  function automatic logic [3:0] posval(input int p); // position weight in syndrome
    return (p >= 1 && p <= 12) ? 4'(p) : 4'd0;
  endfunction

  task automatic fail_msg(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic dec_check(input logic [12:0] w, input logic [7:0] ed,
                           input logic [3:0] es, input logic [1:0] est,
                           input string req);
    @(negedge clk);
    dec_word_i  = w;
    dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
    n_chk++;
    if (dec_valid_o !== 1'b1) fail_msg("R3", "dec_valid_o", 32'(dec_valid_o), 1);
    else if (dec_data_o !== ed) fail_msg(req, "data", 32'(dec_data_o), 32'(ed));
    else if (dec_syndrome_o !== es) fail_msg("R4", "syndrome", 32'(dec_syndrome_o), 32'(es));
    else if (dec_status_o !== est) fail_msg(req, "status", 32'(dec_status_o), 32'(est));
    else if (dec_uncorr_o !== (est == 2'd2)) fail_msg("R8", "uncorr", 32'(dec_uncorr_o), 32'(est == 2'd2));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [12:0] good;
    logic [12:0] bad;
    rst = 1'b1; enc_valid_i = 1'b0; enc_data_i = '0;
    dec_valid_i = 1'b0; dec_word_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++; // R11 reset state
    if (enc_valid_o !== 1'b0 || dec_valid_o !== 1'b0)
      fail_msg("R11", "valids in reset", {enc_valid_o, dec_valid_o}, 0);
    rst = 1'b0;

    // vector table
    for (int t = 0; t < 8; t++)
      dec_check(TBL[t][28:16], TBL[t][15:8], TBL[t][7:4], TBL[t][1:0], "R6");

    // encoder over all bytes (R1, R2)
    for (int d = 0; d < 256; d++) begin
      @(negedge clk);
      enc_data_i  = 8'(d);
      enc_valid_i = 1'b1;
      @(negedge clk);
      enc_valid_i = 1'b0;
      n_chk++;
      if (enc_valid_o !== 1'b1) fail_msg("R2", "enc_valid_o", 32'(enc_valid_o), 1);
      else if (enc_word_o !== m_encode(8'(d)))
        fail_msg("R1", "enc_word", 32'(enc_word_o), 32'(m_encode(8'(d))));
    end
    @(negedge clk);
    n_chk++;
    if (enc_valid_o !== 1'b0) fail_msg("R2", "enc_valid_o idle", 32'(enc_valid_o), 0);

    // exhaustive decode: clean, singles, doubles
    for (int d = 0; d < 256; d++) begin
      good = m_encode(8'(d));
      dec_check(good, 8'(d), 4'd0, 2'd0, "R5");
      for (int p = 1; p <= 13; p++) begin
        bad = good ^ (13'd1 << (p - 1));
        if (p == 13) dec_check(bad, 8'(d), 4'd0, 2'd3, "R7");
        else         dec_check(bad, 8'(d), posval(p), 2'd1, "R6");
      end
      for (int p = 1; p <= 13; p++)
        for (int q = p + 1; q <= 13; q++) begin
          bad = good ^ (13'd1 << (p - 1)) ^ (13'd1 << (q - 1));
          dec_check(bad, m_extract(bad), posval(p) ^ posval(q), 2'd2, "R8");
        end
    end

    // R10 hold while idle, R3 valid low
    dec_check(13'h129D, 8'hC4, 4'd1, 2'd1, "R6");
    @(negedge clk);
    dec_word_i = 13'h0F77 ^ 13'h0003;
    repeat (3) @(negedge clk);
    n_chk++;
    if (dec_valid_o !== 1'b0) fail_msg("R3", "dec_valid_o idle", 32'(dec_valid_o), 0);
    n_chk++;
    if (dec_data_o !== 8'hC4 || dec_status_o !== 2'd1 || dec_syndrome_o !== 4'd1)
      fail_msg("R10", "held outputs", {dec_data_o, dec_syndrome_o, dec_status_o}, {8'hC4, 4'd1, 2'd1});

    // R11 reset mid-stream
    @(negedge clk);
    dec_valid_i = 1'b1; enc_valid_i = 1'b1; rst = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0; enc_valid_i = 1'b0;
    n_chk++;
    if (enc_valid_o !== 1'b0 || dec_valid_o !== 1'b0)
      fail_msg("R11", "valids after reset", {enc_valid_o, dec_valid_o}, 0);
    rst = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule